// File: doc/BRIEF.md
# Saturating BCD Event Counter

This block counts discrete events in decimal. Three request inputs (count up, count down and load) act on their rising edges, so a request held high acts only once. The count saturates at both ends of its range and never wraps. A level-sensitive clear forces the count to zero and locks out every other request while it is high. A separate rearm input lets a controller re-trigger requests that are already held high, without first dropping them.

The count is held as a binary number. It is presented both in binary and as packed decimal digits, together with a flag that is high whenever the count is not zero. The load value is supplied as packed decimal digits. A load value that contains a non-decimal digit is discarded.

Top module: `bcd_event_counter`

## Requirements
- R1: The count stays within 0 to 10^DIGITS-1 (0 to 999 by default). count_bcd always shows the same value as count_bin, with decimal digit i in bits 4i+3:4i and digit 0 as the least significant.
- R2: A rising edge on up_in adds one to the count at the clock edge where the high level is first sampled. Holding up_in high does not add again.
- R3: An up edge at the maximum count leaves the count at the maximum. There is no wrap and no carry.
- R4: A rising edge on down_in subtracts one. A down edge at zero leaves the count at zero.
- R5: A rising edge on load_in copies preset_bcd (same digit layout as R1) into the count. A load edge takes precedence over up and down edges in the same cycle.
- R6: A load edge whose preset_bcd has any digit above 9 leaves the count unchanged, including any up or down edge in that cycle.
- R7: While clear_in is high, the count is zero from the next clock on, and up, down and load have no effect. A request input held high across the fall of clear_in does not count as an edge.
- R8: nonzero is 1 exactly when the count is not zero.
- R9: A rising edge on rearm_in acts as a fresh rising edge on each of up_in, down_in and load_in that is high in that cycle.
- R10: Up and down edges in the same cycle, with no load edge, leave the count unchanged.
- R11: Reset is synchronous and active low. It sets the count to zero and records every request input and rearm_in as previously low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_in | input | 1 | Count-up request, edge-acting |
| down_in | input | 1 | Count-down request, edge-acting |
| load_in | input | 1 | Load-preset request, edge-acting |
| clear_in | input | 1 | Static clear, level-acting, highest priority |
| rearm_in | input | 1 | Re-trigger of held requests on its rising edge |
| preset_bcd | input | 4*DIGITS | Packed decimal load value |
| count_bin | output | CW | Count in binary |
| count_bcd | output | 4*DIGITS | Count as packed decimal digits |
| nonzero | output | 1 | High when the count is not zero |

## Verification
The hardest states to reach from the ports are those that depend on the edge memory rather than the present levels. Examples are a request held across the end of a clear, and the rearm input firing on a request that has been high for many cycles. The stimulus builds these states in sequence: it holds up_in and load_in through a clear, checks that releasing the clear does nothing, and then pulses rearm_in with different subsets of requests held. Both saturation limits are reached by walking the full range one pulse at a time in each direction, and every valid preset is loaded once.

// File: rtl/bcd_ctr_pkg.sv
// Shared types for the saturating decimal event counter.
// Assumes: used by all counter submodules; no state of its own.
package bcd_ctr_pkg;

    // Action selected for the count register in one cycle.
    typedef enum logic [2:0] {
        ACT_HOLD  = 3'd0,
        ACT_CLEAR = 3'd1,
        ACT_LOAD  = 3'd2,
        ACT_INC   = 3'd3,
        ACT_DEC   = 3'd4
    } ctr_act_e;

    // Number of request inputs that go through edge detection.
    localparam int unsigned NUM_REQ = 3;
    localparam int unsigned REQ_UP   = 0;
    localparam int unsigned REQ_DOWN = 1;
    localparam int unsigned REQ_LOAD = 2;

endpackage

// File: rtl/bcd_ctr_edge.sv
// Rising-edge detector for a group of request levels with a shared rearm.
// fire[i] is high in the cycle where lvl[i] is high after having been low,
// or where rearm rises while lvl[i] is high.
// Assumes: synchronous active-low reset; the memory reads as all low after it.
module bcd_ctr_edge #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    input  logic         rearm,
    output logic [N-1:0] fire
);

    logic [N-1:0] lvl_q;
    logic         rearm_q;
    logic         rearm_rise;

    // Remember last-cycle levels of the requests and of rearm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q   <= '0;
            rearm_q <= 1'b0;
        end else begin
            lvl_q   <= lvl;
            rearm_q <= rearm;
        end
    end

    // Rearm rising edge, shared by all request lanes.
    assign rearm_rise = rearm & ~rearm_q;

    // One lane per request: a native edge or a rearm-triggered re-fire.
    for (genvar i = 0; i < N; i++) begin : g_lane
        assign fire[i] = lvl[i] & (~lvl_q[i] | rearm_rise);
    end

endmodule

// File: rtl/bcd_ctr_preset.sv
// Converts a packed decimal load value to binary and flags bad digits.
// Assumes: digit i sits in bits 4i+3:4i, digit 0 least significant.
module bcd_ctr_preset #(
    parameter int unsigned DIGITS = 3,
    parameter int unsigned CW     = 10
) (
    input  logic [4*DIGITS-1:0] bcd_in,
    output logic [CW-1:0]       bin_out,
    output logic                valid
);

    logic [DIGITS-1:0] digit_ok;

    // Per-digit range check.
    for (genvar i = 0; i < DIGITS; i++) begin : g_chk
        assign digit_ok[i] = (bcd_in[4*i +: 4] <= 4'd9);
    end

    assign valid = &digit_ok;

    // Horner accumulation from the most significant digit downward.
    always_comb begin
        bin_out = '0;
        for (int i = DIGITS - 1; i >= 0; i--) begin
            bin_out = CW'(bin_out * CW'(10)) + CW'(bcd_in[4*i +: 4]);
        end
    end

endmodule

// File: rtl/bcd_ctr_digits.sv
// Presents a binary count as packed decimal digits.
// Assumes: the input never exceeds 10^DIGITS-1, so every digit fits 0..9.
module bcd_ctr_digits #(
    parameter int unsigned DIGITS = 3,
    parameter int unsigned CW     = 10
) (
    input  logic [CW-1:0]       bin_in,
    output logic [4*DIGITS-1:0] bcd_out
);

    // Repeated divide by ten, least significant digit first.
    always_comb begin
        logic [CW-1:0] rest;
        rest    = bin_in;
        bcd_out = '0;
        for (int i = 0; i < DIGITS; i++) begin
            bcd_out[4*i +: 4] = 4'(rest % CW'(10));
            rest              = rest / CW'(10);
        end
    end

endmodule

// File: rtl/bcd_event_counter.sv
// Saturating up/down decimal event counter with static clear and rearm.
// Requests act on rising edges; clear acts on level and blocks all else.
// Priority per cycle: clear, then load (dropped when the preset is not
// decimal), then up+down cancel, then single up or down with saturation.
// Assumes: synchronous active-low reset; all inputs synchronous to clk.
module bcd_event_counter
    import bcd_ctr_pkg::*;
#(
    parameter int unsigned DIGITS = 3,
    localparam int unsigned MAXV  = (10 ** DIGITS) - 1,
    localparam int unsigned CW    = $clog2(MAXV + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                up_in,
    input  logic                down_in,
    input  logic                load_in,
    input  logic                clear_in,
    input  logic                rearm_in,
    input  logic [4*DIGITS-1:0] preset_bcd,
    output logic [CW-1:0]       count_bin,
    output logic [4*DIGITS-1:0] count_bcd,
    output logic                nonzero
);

    logic [NUM_REQ-1:0] req_lvl;
    logic [NUM_REQ-1:0] req_fire;
    logic [CW-1:0]      preset_bin;
    logic               preset_ok;
    logic [CW-1:0]      count_q;
    ctr_act_e           act;

    // Gather request levels into lanes for the edge detector.
    assign req_lvl[REQ_UP]   = up_in;
    assign req_lvl[REQ_DOWN] = down_in;
    assign req_lvl[REQ_LOAD] = load_in;

    bcd_ctr_edge #(.N(NUM_REQ)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (req_lvl),
        .rearm (rearm_in),
        .fire  (req_fire)
    );

    bcd_ctr_preset #(.DIGITS(DIGITS), .CW(CW)) u_preset (
        .bcd_in  (preset_bcd),
        .bin_out (preset_bin),
        .valid   (preset_ok)
    );

    // Choose this cycle's action by fixed priority.
    always_comb begin
        act = ACT_HOLD;
        if (clear_in) begin
            act = ACT_CLEAR;
        end else if (req_fire[REQ_LOAD]) begin
            act = preset_ok ? ACT_LOAD : ACT_HOLD;
        end else if (req_fire[REQ_UP] && req_fire[REQ_DOWN]) begin
            act = ACT_HOLD;
        end else if (req_fire[REQ_UP]) begin
            act = (count_q == CW'(MAXV)) ? ACT_HOLD : ACT_INC;
        end else if (req_fire[REQ_DOWN]) begin
            act = (count_q == '0) ? ACT_HOLD : ACT_DEC;
        end
    end

    // Count register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            unique case (act)
                ACT_CLEAR: count_q <= '0;
                ACT_LOAD:  count_q <= preset_bin;
                ACT_INC:   count_q <= count_q + CW'(1);
                ACT_DEC:   count_q <= count_q - CW'(1);
                default:   count_q <= count_q;
            endcase
        end
    end

    bcd_ctr_digits #(.DIGITS(DIGITS), .CW(CW)) u_digits (
        .bin_in  (count_q),
        .bcd_out (count_bcd)
    );

    assign count_bin = count_q;
    assign nonzero   = |count_q;

endmodule

// File: rtl/bcd_ctr_checker.sv
// Property checker for the decimal event counter, bound to the top module.
// Assumes: observes ports only; sync active-low reset disables the checks.
module bcd_ctr_checker #(
    parameter int unsigned DIGITS = 3,
    localparam int unsigned MAXV  = (10 ** DIGITS) - 1,
    localparam int unsigned CW    = $clog2(MAXV + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                up_in,
    input logic                down_in,
    input logic                load_in,
    input logic                clear_in,
    input logic [CW-1:0]       count_bin,
    input logic [4*DIGITS-1:0] count_bcd,
    input logic                nonzero
);

    p_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count_bin <= CW'(MAXV));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count_bin == CW'(MAXV) && !clear_in && !load_in && !down_in)
        |=> count_bin == CW'(MAXV));

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (count_bin == '0 && !clear_in && !load_in && !up_in)
        |=> count_bin == '0);

    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_in |=> count_bin == '0);

    p_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        nonzero == (count_bcd != '0));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_in && !down_in && !load_in && !clear_in)
        |=> count_bin == $past(count_bin));

endmodule

bind bcd_event_counter bcd_ctr_checker #(.DIGITS(DIGITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_in     (up_in),
    .down_in   (down_in),
    .load_in   (load_in),
    .clear_in  (clear_in),
    .count_bin (count_bin),
    .count_bcd (count_bcd),
    .nonzero   (nonzero)
);

// File: tb/bcd_event_counter_test.sv
module bcd_event_counter_test;

    localparam int DIGITS = 3;
    localparam int MAXV   = 999;
    localparam int CW     = 10;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                up_in = 1'b0, down_in = 1'b0, load_in = 1'b0;
    logic                clear_in = 1'b0, rearm_in = 1'b0;
    logic [4*DIGITS-1:0] preset_bcd = '0;
    logic [CW-1:0]       count_bin;
    logic [4*DIGITS-1:0] count_bcd;
    logic                nonzero;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;
    logic pu = 0, pd = 0, pl = 0, pr = 0;
    bit done = 0;

    bcd_event_counter #(.DIGITS(DIGITS)) uut (
        .clk(clk), .rst_n(rst_n), .up_in(up_in), .down_in(down_in),
        .load_in(load_in), .clear_in(clear_in), .rearm_in(rearm_in),
        .preset_bcd(preset_bcd), .count_bin(count_bin),
        .count_bcd(count_bcd), .nonzero(nonzero)
    );

    always #2 clk = ~clk;

    function automatic logic [11:0] to_bcd(int v);
        return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    function automatic bit bcd_ok(logic [11:0] p);
        return p[3:0] <= 9 && p[7:4] <= 9 && p[11:8] <= 9;
    endfunction

    function automatic int from_bcd(logic [11:0] p);
        return int'(p[11:8]) * 100 + int'(p[7:4]) * 10 + int'(p[3:0]);
    endfunction

    task automatic check(string tag);
        checks++;
        if (count_bin !== CW'(exp_cnt)) begin
            errors++;
            $display("FAIL %s count_bin actual=%0d expected=%0d", tag, count_bin, exp_cnt);
        end
        checks++;
        if (count_bcd !== to_bcd(exp_cnt)) begin
            errors++;
            $display("FAIL R1 (%s) count_bcd actual=%h expected=%h", tag, count_bcd, to_bcd(exp_cnt));
        end
        checks++;
        if (nonzero !== (exp_cnt != 0)) begin
            errors++;
            $display("FAIL R8 (%s) nonzero actual=%b expected=%b", tag, nonzero, exp_cnt != 0);
        end
    endtask

    // One clock: apply inputs, advance, update expected value, check.
    task automatic cyc(logic rn, logic u, logic d, logic l, logic c, logic r,
                       logic [11:0] p, string tag);
        bit rr, eu, ed, el;
        @(negedge clk);
        rst_n = rn; up_in = u; down_in = d; load_in = l;
        clear_in = c; rearm_in = r; preset_bcd = p;
        @(posedge clk);
        #1;
        rr = r && !pr;
        eu = u && (!pu || rr);
        ed = d && (!pd || rr);
        el = l && (!pl || rr);
        if (!rn) begin
            exp_cnt = 0; pu = 0; pd = 0; pl = 0; pr = 0;
        end else begin
            if (c) exp_cnt = 0;
            else if (el) begin
                if (bcd_ok(p)) exp_cnt = from_bcd(p);
            end else if (eu && ed) exp_cnt = exp_cnt;
            else if (eu) exp_cnt = (exp_cnt == MAXV) ? MAXV : exp_cnt + 1;
            else if (ed) exp_cnt = (exp_cnt == 0) ? 0 : exp_cnt - 1;
            pu = u; pd = d; pl = l; pr = r;
        end
        check(tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (3) cyc(0, 0, 0, 0, 0, 0, '0, "R11");

        // R2/R3: walk up past the top one pulse at a time
        for (int i = 0; i <= MAXV + 1; i++) begin
            cyc(1, 1, 0, 0, 0, 0, '0, "R2");
            cyc(1, 0, 0, 0, 0, 0, '0, "R3");
        end
        // R2: held high counts only once
        cyc(1, 0, 1, 0, 0, 0, '0, "R4");
        cyc(1, 0, 0, 0, 0, 0, '0, "R4");
        repeat (4) cyc(1, 1, 0, 0, 0, 0, '0, "R2");
        cyc(1, 0, 0, 0, 0, 0, '0, "R2");

        // R4: walk down past zero
        for (int i = 0; i <= MAXV + 1; i++) begin
            cyc(1, 0, 1, 0, 0, 0, '0, "R4");
            cyc(1, 0, 0, 0, 0, 0, '0, "R4");
        end

        // R5: every valid preset
        for (int v = 0; v <= MAXV; v++) begin
            cyc(1, 0, 0, 1, 0, 0, to_bcd(v), "R5");
            cyc(1, 0, 0, 0, 0, 0, '0, "R5");
        end

        // R6: non-decimal digit in each position, with counting requests too
        cyc(1, 0, 0, 1, 0, 0, 12'h500, "R5");
        cyc(1, 0, 0, 0, 0, 0, '0, "R5");
        for (int pos = 0; pos < 3; pos++) begin
            for (int dv = 10; dv < 16; dv++) begin
                logic [11:0] bad;
                bad = 12'h123;
                bad[4*pos +: 4] = 4'(dv);
                cyc(1, dv[0], 0, 1, 0, 0, bad, "R6");
                cyc(1, 0, 0, 0, 0, 0, '0, "R6");
            end
        end

        // R5: load beats up and down in the same cycle
        cyc(1, 1, 1, 1, 0, 0, 12'h042, "R5");
        cyc(1, 0, 0, 0, 0, 0, '0, "R5");
        // R10: up and down together cancel
        cyc(1, 1, 1, 0, 0, 0, '0, "R10");
        cyc(1, 0, 0, 0, 0, 0, '0, "R10");
        cyc(1, 1, 0, 0, 0, 0, '0, "R10");
        cyc(1, 1, 1, 0, 0, 0, '0, "R10");

        // R7: clear blocks requests; held requests across release do nothing
        cyc(1, 0, 0, 0, 0, 0, '0, "R7");
        cyc(1, 1, 0, 0, 1, 0, '0, "R7");
        cyc(1, 0, 0, 1, 1, 0, 12'h777, "R7");
        cyc(1, 1, 0, 1, 1, 0, 12'h777, "R7");
        cyc(1, 1, 0, 0, 0, 0, 12'h777, "R7");
        cyc(1, 1, 0, 0, 0, 0, 12'h777, "R7");

        // R9: rearm refires the held up request
        cyc(1, 1, 0, 0, 0, 1, '0, "R9");
        cyc(1, 1, 0, 0, 0, 1, '0, "R9");
        cyc(1, 1, 0, 0, 0, 0, '0, "R9");
        cyc(1, 1, 0, 0, 0, 1, '0, "R9");
        // R9: rearm with held load re-loads
        cyc(1, 0, 0, 1, 0, 0, 12'h300, "R9");
        cyc(1, 0, 0, 1, 0, 0, 12'h250, "R9");
        cyc(1, 0, 0, 1, 0, 0, 12'h250, "R9");
        cyc(1, 0, 0, 1, 0, 1, 12'h250, "R9");
        // R9: rearm with held down
        cyc(1, 0, 1, 0, 0, 0, '0, "R9");
        cyc(1, 0, 1, 0, 0, 0, '0, "R9");
        cyc(1, 0, 1, 0, 0, 1, '0, "R9");
        cyc(1, 0, 1, 0, 0, 0, '0, "R9");
        // R9: rearm during clear has no effect
        cyc(1, 1, 0, 0, 1, 1, '0, "R9");
        cyc(1, 1, 0, 0, 0, 0, '0, "R9");

        // R11: mid-run reset, then held input after reset counts as an edge
        cyc(1, 0, 0, 1, 0, 0, 12'h321, "R11");
        cyc(0, 1, 0, 0, 0, 0, '0, "R11");
        cyc(1, 1, 0, 0, 0, 0, '0, "R11");
        cyc(1, 0, 0, 0, 0, 0, '0, "R11");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule